// File: doc/BRIEF.md
# Significance-ranked stuck-bit pointer allocator

This block looks after the repair pointers of a single storage block of `BLK_BITS` bits (512 by default) once a write-verify pass has reported which cells are stuck. Each pointer holds a bit position and the bit value that belongs there. The block ends up with a small number of pointers, `NUM_ENT` (two by default). A read through the block returns the raw cell data with every pointed-at position replaced by the stored bit.

Every write request carries a precision flag and a 3-bit size code. The size code says how wide the identical elements packed into the block are. When a request reports at least one failure that the block has not seen before, a fixed-length sequential scan rebuilds the pointers. Failed bits are taken in significance order: the bit index modulo the element width ranks them, and the lower absolute position wins a tie. A precise request with more failures than pointers raises a one-cycle interrupt carrying the block's identifier, and the block is flagged approximate from then on. An approximate request never interrupts. It repairs the most significant failures and leaves the rest as they are. A request that reports no new failure leaves the pointers alone and completes at once.

Top module: `stuckbit_ptr_alloc`

## Requirements
- R1: After reset no pointer is valid, and `done`, `irq` and `blk_approx` are low.
- R2: A precise request whose failure count is at most `NUM_ENT` gets one valid pointer per failed bit. Each pointer's `ent_bit` equals `wr_data` at its position, unused pointers stay invalid and `irq` stays low.
- R3: A precise request with more failures than `NUM_ENT` pulses `irq` in the `done` cycle with `irq_blk_id` equal to the request's `blk_id`. `blk_approx` goes high on the next edge and stays high until reset.
- R4: An approximate request never raises `irq`. When its failures exceed `NUM_ENT`, all `NUM_ENT` pointers are filled and the remaining failures are left uncorrected.
- R5: Element width is 8·2^code bits, and code 7 means the whole block. Within an element, bit 0 is the most significant. Failures are ranked by position mod element width, lowest first. Pointer 0 gets the best rank, pointer 1 the next, and so on.
- R6: Failures with equal rank are ordered by lower absolute bit position first.
- R7: A request whose `fail_mask` holds no bit outside the union of all masks seen since reset raises `done` after the first clock edge. The pointers are left unchanged and `irq` stays low.
- R8: A request that reports a new failure raises `done` after `BLK_BITS+1` clock edges, counting the edge that samples `start`. `done` lasts one cycle.
- R9: `rd_fixed` equals `rd_raw` except at the positions of valid pointers, where it carries that pointer's stored bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| precise | input | 1 | 1 = precise write, 0 = approximate write |
| size_code | input | 3 | Element size, 2^code bytes |
| blk_id | input | ID_W | Identifier of the storage block |
| fail_mask | input | BLK_BITS | Stuck-bit positions found by verify |
| wr_data | input | BLK_BITS | Data the write intended to store |
| rd_raw | input | BLK_BITS | Raw data read from the cells |
| rd_fixed | output | BLK_BITS | Read data with pointers applied |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Precise overflow interrupt, coincident with done |
| irq_blk_id | output | ID_W | Block identifier reported with irq |
| blk_approx | output | 1 | Block is no longer usable for precise data |
| ent_valid | output | NUM_ENT | Valid flag per pointer |
| ent_pos | output | NUM_ENT·POS_W | Bit position per pointer, pointer 0 in the low bits |
| ent_bit | output | NUM_ENT | Replacement bit per pointer |

## Verification
The bench uses the default 512-bit block, two pointers and a 12-bit identifier. With these values the full 513-edge scan latency can be measured directly. Three or four failures then overflow the pointer budget, which exercises ranking, overflow and the interrupt. Size codes 0, 3 and 7 cover 8-bit, 64-bit and whole-block elements, so the tie rule shows up with small elements and the code-7 clamp is covered as well.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

    localparam int unsigned CODE_W = 3;
    localparam int unsigned LG_W   = 4;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SCAN = 2'd1,
        S_DONE = 2'd2
    } sbp_state_e;

    typedef struct packed {
        logic              precise;
        logic [CODE_W-1:0] code;
    } sbp_req_t;

    // log2 of the element width in bits, clamped to the block width
    function automatic logic [LG_W-1:0] elem_lg(input logic [CODE_W-1:0] code,
                                                 input int unsigned pos_w);
        int unsigned lg;
        lg = 3 + int'(code);
        if (lg > pos_w) lg = pos_w;
        return LG_W'(lg);
    endfunction

endpackage

// File: rtl/sbp_order_map.sv
// Maps a scan index to a bit position so that indices walk the block
// in rank order: rank (position mod width) major, element number minor.
module sbp_order_map #(
    parameter int unsigned POS_W = 9
) (
    input  logic [POS_W-1:0]          idx,
    input  logic [sbp_pkg::LG_W-1:0]  lgw,
    output logic [POS_W-1:0]          pos
);
    logic [POS_W-1:0] elem_mask;
    logic [POS_W-1:0] elem_num;
    logic [POS_W-1:0] rank;

    always_comb begin
        elem_mask = {POS_W{1'b1}} >> lgw;
        elem_num  = idx & elem_mask;
        rank      = idx >> (POS_W - int'(lgw));
        pos       = (elem_num << lgw) | rank;
    end
endmodule

// File: rtl/sbp_entry_bank.sv
module sbp_entry_bank #(
    parameter int unsigned BLK_BITS = 512,
    parameter int unsigned NUM_ENT  = 2,
    localparam int unsigned POS_W   = $clog2(BLK_BITS),
    localparam int unsigned FILL_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     wr_en,
    input  logic [FILL_W-1:0]        wr_idx,
    input  logic [POS_W-1:0]         wr_pos,
    input  logic                     wr_bit,
    input  logic [BLK_BITS-1:0]      rd_raw,
    output logic [BLK_BITS-1:0]      rd_fixed,
    output logic [NUM_ENT-1:0]       ent_valid,
    output logic [NUM_ENT*POS_W-1:0] ent_pos,
    output logic [NUM_ENT-1:0]       ent_bit
);
    logic [POS_W-1:0] pos_q [NUM_ENT];

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ent_valid[i] <= 1'b0;
                ent_bit[i]   <= 1'b0;
                pos_q[i]     <= '0;
            end else if (wr_en && (wr_idx == FILL_W'(i))) begin
                ent_valid[i] <= 1'b1;
                ent_bit[i]   <= wr_bit;
                pos_q[i]     <= wr_pos;
            end
        end
        assign ent_pos[i*POS_W +: POS_W] = pos_q[i];
    end

    always_comb begin
        rd_fixed = rd_raw;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (ent_valid[i]) rd_fixed[pos_q[i]] = ent_bit[i];
        end
    end

    if (NUM_ENT > 1) begin : g_chk
        AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (rst)
            ent_valid[1] |-> ent_valid[0]); // R5
        AST_DISTINCT_POS: assert property (@(posedge clk) disable iff (rst)
            (ent_valid[0] && ent_valid[1]) |-> (pos_q[0] != pos_q[1])); // R2
    end
endmodule

// File: rtl/stuckbit_ptr_alloc.sv
module stuckbit_ptr_alloc #(
    parameter int unsigned BLK_BITS = 512,
    parameter int unsigned NUM_ENT  = 2,
    parameter int unsigned ID_W     = 12,
    localparam int unsigned POS_W   = $clog2(BLK_BITS),
    localparam int unsigned FILL_W  = $clog2(NUM_ENT + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     precise,
    input  logic [2:0]               size_code,
    input  logic [ID_W-1:0]          blk_id,
    input  logic [BLK_BITS-1:0]      fail_mask,
    input  logic [BLK_BITS-1:0]      wr_data,
    input  logic [BLK_BITS-1:0]      rd_raw,
    output logic [BLK_BITS-1:0]      rd_fixed,
    output logic                     done,
    output logic                     irq,
    output logic [ID_W-1:0]          irq_blk_id,
    output logic                     blk_approx,
    output logic [NUM_ENT-1:0]       ent_valid,
    output logic [NUM_ENT*POS_W-1:0] ent_pos,
    output logic [NUM_ENT-1:0]       ent_bit
);
    import sbp_pkg::*;

    sbp_state_e          st;
    sbp_req_t            req_q;
    logic [ID_W-1:0]     id_q;
    logic [BLK_BITS-1:0] mask_q;
    logic [BLK_BITS-1:0] data_q;
    logic [BLK_BITS-1:0] known_q;
    logic [POS_W-1:0]    cnt;
    logic [POS_W:0]      nfail;
    logic [FILL_W-1:0]   fill;

    logic [LG_W-1:0]     lgw;
    logic [POS_W-1:0]    scan_pos;
    logic                hit;
    logic                ent_wr;
    logic                accept;
    logic                has_new;

    assign lgw     = elem_lg(req_q.code, POS_W);
    assign hit     = (st == S_SCAN) && mask_q[scan_pos];
    assign ent_wr  = hit && (fill < FILL_W'(NUM_ENT));
    assign accept  = (st == S_IDLE) && start;
    assign has_new = |(fail_mask & ~known_q);

    sbp_order_map #(.POS_W(POS_W)) u_order (
        .idx (cnt),
        .lgw (lgw),
        .pos (scan_pos)
    );

    sbp_entry_bank #(.BLK_BITS(BLK_BITS), .NUM_ENT(NUM_ENT)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .clr       (accept && has_new),
        .wr_en     (ent_wr),
        .wr_idx    (fill),
        .wr_pos    (scan_pos),
        .wr_bit    (data_q[scan_pos]),
        .rd_raw    (rd_raw),
        .rd_fixed  (rd_fixed),
        .ent_valid (ent_valid),
        .ent_pos   (ent_pos),
        .ent_bit   (ent_bit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= S_IDLE;
            req_q      <= '0;
            id_q       <= '0;
            mask_q     <= '0;
            data_q     <= '0;
            known_q    <= '0;
            cnt        <= '0;
            nfail      <= '0;
            fill       <= '0;
            blk_approx <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (start) begin
                    req_q.precise <= precise;
                    req_q.code    <= size_code;
                    id_q          <= blk_id;
                    mask_q        <= fail_mask;
                    data_q        <= wr_data;
                    known_q       <= known_q | fail_mask;
                    cnt           <= '0;
                    nfail         <= '0;
                    fill          <= '0;
                    st            <= has_new ? S_SCAN : S_DONE;
                end
                S_SCAN: begin
                    if (hit)    nfail <= nfail + 1'b1;
                    if (ent_wr) fill  <= fill + 1'b1;
                    cnt <= cnt + 1'b1;
                    if (cnt == POS_W'(BLK_BITS - 1)) st <= S_DONE;
                end
                S_DONE: begin
                    if (irq) blk_approx <= 1'b1;
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done       = (st == S_DONE);
    assign irq        = done && req_q.precise && (nfail > (POS_W+1)'(NUM_ENT));
    assign irq_blk_id = id_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_IRQ_MARKS: assert property (@(posedge clk) disable iff (rst)
        irq |=> blk_approx); // R3
    AST_APPROX_STICKY: assert property (@(posedge clk) disable iff (rst)
        blk_approx |=> blk_approx); // R3
    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (fill <= FILL_W'(NUM_ENT))); // R4
    AST_ENT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && !start) |=> ($stable(ent_pos) && $stable(ent_valid)
                                      && $stable(ent_bit))); // R7
endmodule

// File: tb/tb_stuckbit_ptr_alloc.sv
module tb_stuckbit_ptr_alloc;
    localparam int unsigned BLK_BITS = 512;
    localparam int unsigned NUM_ENT  = 2;
    localparam int unsigned ID_W     = 12;
    localparam int unsigned POS_W    = 9;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     start = 1'b0;
    logic                     precise = 1'b0;
    logic [2:0]               size_code = '0;
    logic [ID_W-1:0]          blk_id = '0;
    logic [BLK_BITS-1:0]      fail_mask = '0;
    logic [BLK_BITS-1:0]      wr_data = '0;
    logic [BLK_BITS-1:0]      rd_raw = '0;
    logic [BLK_BITS-1:0]      rd_fixed;
    logic                     done;
    logic                     irq;
    logic [ID_W-1:0]          irq_blk_id;
    logic                     blk_approx;
    logic [NUM_ENT-1:0]       ent_valid;
    logic [NUM_ENT*POS_W-1:0] ent_pos;
    logic [NUM_ENT-1:0]       ent_bit;

    int checks = 0;
    int fails  = 0;
    int edges;
    logic irq_seen;

    always #2.5 clk = ~clk;

    stuckbit_ptr_alloc #(.BLK_BITS(BLK_BITS), .NUM_ENT(NUM_ENT), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .start(start), .precise(precise),
        .size_code(size_code), .blk_id(blk_id), .fail_mask(fail_mask),
        .wr_data(wr_data), .rd_raw(rd_raw), .rd_fixed(rd_fixed),
        .done(done), .irq(irq), .irq_blk_id(irq_blk_id),
        .blk_approx(blk_approx), .ent_valid(ent_valid),
        .ent_pos(ent_pos), .ent_bit(ent_bit)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pos_of(int i);
        return int'(ent_pos[i*POS_W +: POS_W]);
    endfunction

    // issue one request and count edges until done is seen
    task automatic run_op(input logic prec, input logic [2:0] code,
                          input logic [ID_W-1:0] id);
        @(negedge clk);
        precise = prec; size_code = code; blk_id = id; start = 1'b1;
        edges = 0;
        irq_seen = 1'b0;
        do begin
            @(posedge clk);
            edges++;
            @(negedge clk);
            start = 1'b0;
        end while (!done && edges < 2000);
        irq_seen = irq;
    endtask

    task automatic t_reset;
        check("R1 ent_valid", int'(ent_valid), 0);
        check("R1 done", int'(done), 0);
        check("R1 irq", int'(irq), 0);
        check("R1 blk_approx", int'(blk_approx), 0);
    endtask

    task automatic t_precise_single;
        fail_mask = '0; fail_mask[100] = 1'b1;
        wr_data = '0; wr_data[100] = 1'b1;
        run_op(1'b1, 3'd3, 12'h011);
        check("R8 scan latency", edges, BLK_BITS + 1);
        check("R2 ent0 valid", int'(ent_valid[0]), 1);
        check("R2 ent1 unused", int'(ent_valid[1]), 0);
        check("R2 ent0 pos", pos_of(0), 100);
        check("R2 ent0 bit", int'(ent_bit[0]), 1);
        check("R2 no irq", int'(irq_seen), 0);
    endtask

    task automatic t_precise_pair;
        fail_mask = '0; fail_mask[100] = 1'b1; fail_mask[7] = 1'b1;
        wr_data = '1; wr_data[7] = 1'b0;
        run_op(1'b1, 3'd3, 12'h012);
        check("R2 pair ent0 pos (rank 7)", pos_of(0), 7);
        check("R2 pair ent1 pos (rank 36)", pos_of(1), 100);
        check("R2 pair ent0 bit", int'(ent_bit[0]), 0);
        check("R2 pair ent1 bit", int'(ent_bit[1]), 1);
        check("R2 pair no irq", int'(irq_seen), 0);
        rd_raw = '0;
        #1;
        check("R9 rd_fixed bit100", int'(rd_fixed[100]), 1);
        check("R9 rd_fixed ones", $countones(rd_fixed), 1);
        rd_raw = '1;
        #1;
        check("R9 rd_fixed bit7", int'(rd_fixed[7]), 0);
        check("R9 rd_fixed zeros", BLK_BITS - $countones(rd_fixed), 1);
    endtask

    task automatic t_approx_over;
        fail_mask = '0;
        fail_mask[5] = 1'b1; fail_mask[70] = 1'b1;
        fail_mask[130] = 1'b1; fail_mask[200] = 1'b1;
        wr_data = '0; wr_data[130] = 1'b1;
        run_op(1'b0, 3'd3, 12'h013);
        check("R4 no irq", int'(irq_seen), 0);
        check("R4 both used", int'(ent_valid), 3);
        check("R5 ent0 pos 130 (rank 2)", pos_of(0), 130);
        check("R5 ent1 pos 5 (rank 5)", pos_of(1), 5);
        check("R4 approx flag", int'(blk_approx), 0);
        rd_raw = '0;
        #1;
        check("R4 bit70 left", int'(rd_fixed[70]), 0);
        check("R9 bit130 fixed", int'(rd_fixed[130]), 1);
    endtask

    task automatic t_tie;
        fail_mask = '0;
        fail_mask[9] = 1'b1; fail_mask[17] = 1'b1; fail_mask[3] = 1'b1;
        wr_data = '0;
        run_op(1'b0, 3'd0, 12'h014);
        check("R6 tie ent0 pos 9", pos_of(0), 9);
        check("R6 tie ent1 pos 17", pos_of(1), 17);
    endtask

    task automatic t_code7;
        fail_mask = '0;
        fail_mask[450] = 1'b1; fail_mask[400] = 1'b1; fail_mask[300] = 1'b1;
        wr_data = '0;
        run_op(1'b0, 3'd7, 12'h015);
        check("R5 code7 ent0 pos 300", pos_of(0), 300);
        check("R5 code7 ent1 pos 400", pos_of(1), 400);
    endtask

    task automatic t_precise_over;
        fail_mask = '0;
        fail_mask[11] = 1'b1; fail_mask[12] = 1'b1; fail_mask[13] = 1'b1;
        wr_data = '0;
        run_op(1'b1, 3'd3, 12'h5A5);
        check("R3 irq", int'(irq_seen), 1);
        check("R3 irq id", int'(irq_blk_id), 'h5A5);
        @(negedge clk);
        check("R3 approx set", int'(blk_approx), 1);
        check("R3 ent0 pos 11", pos_of(0), 11);
        check("R3 ent1 pos 12", pos_of(1), 12);
    endtask

    task automatic t_no_new;
        fail_mask = '0; fail_mask[11] = 1'b1;
        wr_data = '1;
        run_op(1'b1, 3'd0, 12'h016);
        check("R7 fast done", edges, 1);
        check("R7 no irq", int'(irq_seen), 0);
        check("R7 ent0 kept", pos_of(0), 11);
        check("R7 ent1 kept", pos_of(1), 12);
        check("R7 bits kept", int'(ent_bit), 0);
        repeat (3) @(negedge clk);
        check("R3 approx sticky", int'(blk_approx), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_precise_single();
        t_precise_pair();
        t_approx_over();
        t_tie();
        t_code7();
        t_precise_over();
        t_no_new();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule